// File: doc/BRIEF.md
# Hybrid Karatsuba Carry-Less Multiplier

This block multiplies two binary polynomials of width `W` over GF(2). It returns their full product, of width `2W-1`, with no reduction. It is intended as the multiply core of a generic elliptic-curve datapath. A separate reduction stage folds the product back into the field.

The block has no clock and no storage, so the output follows the inputs purely combinationally. Above the smallest size, each operand is cut into a low half and a high half. The block then forms three half-width products: low times low, high times high, and the product of the XOR-folded halves. The middle term is recovered as the folded product XOR both outer products. It is added in at an offset of half the width, and the high product is added in at an offset of the full width. Recursion bottoms out in a 3-by-3 schoolbook cell, where each bit of one operand gates a shifted copy of the other and the copies are XOR-summed.

`W` must have the form 3·2^k (3, 6, 12, 24, 48, ...). Any other value stops elaboration with an error.

Top module: `gf2_kara_mul`

## Requirements
- R1: The product is a pure function of the present operands; a change on the inputs reaches `prod` with no clock edge involved.
- R2: `prod` equals the carry-less product: the XOR over every set bit i of `a_in` of `b_in` shifted left by i, where bit j of each vector is the coefficient of x^j.
- R3: `prod` is 2W-1 bits and unreduced; its top bit, 2W-2, equals `a_in[W-1] & b_in[W-1]`.
- R4: If either operand is zero, `prod` is zero.
- R5: If `a_in` is the constant polynomial 1 (only bit 0 set), `prod` equals `b_in` zero-extended.
- R6: Bit 0 of `prod` equals `a_in[0] & b_in[0]`.
- R7: Swapping the operands leaves `prod` unchanged.
- R8: A single-bit operand x^i times a single-bit operand x^j yields exactly one set bit, at position i+j.
- R9: All-ones times all-ones gives the carry-less square of the all-ones pattern, which is set only at even positions 0, 2, ..., 2W-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand polynomial, bit j = coefficient of x^j |
| b_in | input | W | Second operand polynomial, same encoding |
| prod | output | 2W-1 | Unreduced product polynomial |

## Verification
The bench goes after the seams where the three sub-products overlap. Single-bit operands that straddle the half boundary land in the overlap; a design with a wrong middle-term offset puts that bit one half-width away. The all-ones square produces the cancellations in the middle term; a design that adds the outer products into the middle term with carries instead of XOR shows stray odd bits. Zero halves and the unit operand catch a design that leaks the folded product when one half is empty. Exhaustive 6-bit coverage reaches every path through a single split, and random 48-bit operands drive all four recursion levels.

// File: rtl/gf2_kara_mul.sv
module gf2_kara_mul #(
  parameter int W = 48
) (
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-2:0] prod
);

  localparam int LEAF = 3;
  localparam int H    = W / 2;

  function automatic bit width_ok(int w);
    int v;
    v = w;
    while (v > LEAF && v % 2 == 0) v = v / 2;
    return v == LEAF;
  endfunction

  localparam bit OK = width_ok(W);

  generate
    if (!OK) begin : g_bad
      $error("gf2_kara_mul: W must be 3 times a power of two");
      assign prod = '0;
    end else if (W == LEAF) begin : g_leaf
      logic [2*W-2:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++)
          if (b_in[i]) acc ^= ({{(W-1){1'b0}}, a_in} << i);
      end
      assign prod = acc;
    end else begin : g_split
      logic [2*H-2:0] p_lo, p_hi, p_mid, mid;

      gf2_kara_mul #(.W(H)) u_lo (
        .a_in(a_in[H-1:0]), .b_in(b_in[H-1:0]), .prod(p_lo));
      gf2_kara_mul #(.W(H)) u_hi (
        .a_in(a_in[W-1:H]), .b_in(b_in[W-1:H]), .prod(p_hi));
      gf2_kara_mul #(.W(H)) u_mid (
        .a_in(a_in[H-1:0] ^ a_in[W-1:H]),
        .b_in(b_in[H-1:0] ^ b_in[W-1:H]), .prod(p_mid));

      assign mid  = p_mid ^ p_lo ^ p_hi;
      assign prod = {p_hi, 1'b0, p_lo} ^ {{H{1'b0}}, mid, {H{1'b0}}};
    end
  endgenerate

  always_comb begin
    // R4
    if (a_in == '0 || b_in == '0)
      zero_operand_chk: assert (prod == '0)
        else $error("zero operand gave nonzero product");
    // R5
    if (a_in == W'(1))
      unit_operand_chk: assert (prod == {{(W-1){1'b0}}, b_in})
        else $error("unit operand did not pass other operand");
    // R3
    top_bit_chk: assert (prod[2*W-2] == (a_in[W-1] & b_in[W-1]))
      else $error("top product bit wrong");
    // R6
    low_bit_chk: assert (prod[0] == (a_in[0] & b_in[0]))
      else $error("lowest product bit wrong");
  end

endmodule

// File: tb/gf2_kara_mul_test.sv
module gf2_kara_mul_test;

  localparam int CLK_PERIOD = 10;
  localparam int WB = 48;
  localparam int WS = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WB-1:0]   a48 = '0, b48 = '0;
  logic [2*WB-2:0] p48;
  logic [WS-1:0]   a6 = '0, b6 = '0;
  logic [2*WS-2:0] p6;

  gf2_kara_mul #(.W(WB)) uut   (.a_in(a48), .b_in(b48), .prod(p48));
  gf2_kara_mul #(.W(WS)) uut_s (.a_in(a6),  .b_in(b6),  .prod(p6));

  int checks = 0;
  int fails  = 0;

  function automatic logic [2*WB-2:0] clmul(input logic [WB-1:0] a, input logic [WB-1:0] b);
    logic [2*WB-2:0] r;
    r = '0;
    for (int i = 0; i < WB; i++)
      if (a[i]) r ^= ({{(WB-1){1'b0}}, b} << i);
    return r;
  endfunction

  task automatic check(input string tag, input logic [2*WB-2:0] act, input logic [2*WB-2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [WB-1:0] a, input logic [WB-1:0] b, input string tag);
    @(posedge clk);
    a48 = a; b48 = b;
    @(negedge clk);
    check(tag, p48, clmul(a, b));
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [2*WB-2:0] first, ones_sq;
    void'($urandom(32'd20240917));

    // R4: idle inputs at start give zero
    @(negedge clk);
    check("R4 initial zero", p48, '0);

    // R1: response without a clock edge
    @(posedge clk);
    a48 = 48'h0000_0000_00F3; b48 = 48'h0000_0000_0105;
    #1;
    check("R1 no-edge response", p48, clmul(48'hF3, 48'h105));
    b48 = 48'h8000_0000_0001;
    #1;
    check("R1 second change", p48, clmul(48'hF3, 48'h8000_0000_0001));

    // R4: zero operands with busy other side
    run('0, 48'hDEAD_BEEF_1234, "R4 zero a");
    run(48'hFFFF_0000_FFFF, '0, "R4 zero b");
    run({24'h0, 24'hABCDEF}, {24'h123456, 24'h0}, "R4 zero halves R2");

    // R5: unit operand
    run(48'h1, 48'hA5A5_5A5A_C3C3, "R5 unit a");
    @(negedge clk);
    check("R5 unit a passthrough", p48, {{(WB-1){1'b0}}, 48'hA5A5_5A5A_C3C3});

    // R8: single-bit operands, including half-boundary straddles
    for (int i = 0; i < WB; i += 5)
      for (int j = 0; j < WB; j += 7) begin
        run(48'h1 << i, 48'h1 << j, "R8 single bits");
        check("R8 position", p48, {{(WB-1){1'b0}}, 1'b1} << (i + j));
      end
    run(48'h1 << 23, 48'h1 << 24, "R8 straddle mid");
    run(48'h1 << 47, 48'h1 << 47, "R8 top bits R3");
    check("R3 top bit set", {94'h0, p48[2*WB-2]}, 95'h1);

    // R9: all-ones square
    ones_sq = '0;
    for (int k = 0; k < 2*WB-1; k += 2) ones_sq[k] = 1'b1;
    run('1, '1, "R9 all ones");
    check("R9 even pattern", p48, ones_sq);

    // R6 / R3: boundary bits
    run(48'h8000_0000_0001, 48'h8000_0000_0001, "R6 R3 end bits");
    check("R6 low bit", {94'h0, p48[0]}, 95'h1);

    // R7: commutation
    for (int n = 0; n < 40; n++) begin
      logic [WB-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      run(x, y, "R7 forward");
      first = p48;
      run(y, x, "R7 reverse");
      check("R7 commutes", p48, first);
    end

    // R2: random wide operands
    for (int n = 0; n < 1500; n++) begin
      logic [WB-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (n % 10 == 0) x[WB-1:WB/2] = '0;
      if (n % 10 == 5) y = ~y;
      run(x, y, "R2 random 48");
    end

    // R2: exhaustive 6-bit
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        logic [2*WB-2:0] e;
        @(posedge clk);
        a6 = x[WS-1:0]; b6 = y[WS-1:0];
        @(negedge clk);
        e = clmul({42'h0, x[WS-1:0]}, {42'h0, y[WS-1:0]});
        check("R2 exhaustive 6", {84'h0, p6}, e);
      end

    finish_up();
  end

endmodule